// File: doc/BRIEF.md
# 8-bit ALU with Flag Generation

This block is the arithmetic and logic datapath of a small 8-bit processor. Each cycle it takes two operand bytes, a 4-bit operation code and the current carry flag. It computes a result byte, new zero (Z), digit-carry (DC) and carry (C) flag values, and a three-bit update mask. The mask tells the surrounding status register which of the three flags the operation is allowed to change. All outputs are registered, so a result appears one clock edge after its inputs.

Subtraction is done by adding the two's complement of the subtrahend. This makes C and DC inverted borrows: a value of 1 means no borrow occurred. Rotates move bits through the carry flag: the incoming carry fills the vacated bit, and the bit shifted out becomes the new carry. Logic operations, increment and decrement touch only Z. Nibble swap and pass-through leave every flag alone. A flag that is outside the mask is always driven as 0.

The data width is the parameter `DATA_W`, with the nibble boundary at `DATA_W/2`. The value 8 is the intended configuration.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 (add) yields res = (a + b) mod 256. C is the carry out of bit 7 and DC is the carry out of bit 3. The mask enables Z, DC and C.
- R2: Operation code 1 (subtract) yields res = (a - b) mod 256. C = 1 exactly when a >= b, and DC = 1 exactly when a[3:0] >= b[3:0]. The mask enables Z, DC and C.
- R3: For every operation whose mask enables Z, Z is 1 exactly when the registered 8-bit result is zero.
- R4: Operation codes 2, 3 and 4 yield a AND b, a OR b and a XOR b respectively. The mask enables Z only.
- R5: Operation code 5 (rotate left through carry) yields {a[6:0], c_in} with C = a[7]. Operation code 6 (rotate right through carry) yields {c_in, a[7:1]} with C = a[0]. For both, the mask enables C only.
- R6: Operation code 7 yields a with its nibbles swapped, {a[3:0], a[7:4]}. Operation code 10 passes a through unchanged. For both, the mask is empty.
- R7: Operation code 8 yields (a + 1) mod 256 and operation code 9 yields (a - 1) mod 256. For both, the mask enables Z only.
- R8: A flag output whose mask bit is 0 reads 0. Operation codes 11 to 15 yield a result of 0 with an empty mask.
- R9: Outputs take the values for the inputs present at the previous rising clock edge. A synchronous active-high reset clears the result, flag and mask registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select (codes in R1 to R8) |
| opd_a | input | DATA_W | First operand; source of rotate, swap, increment, decrement and pass |
| opd_b | input | DATA_W | Second operand; subtracted from opd_a |
| c_in | input | 1 | Current carry flag, used by rotates |
| res_q | output | DATA_W | Registered result byte |
| z_q | output | 1 | Registered zero flag |
| dc_q | output | 1 | Registered digit-carry / inverted digit-borrow flag |
| c_q | output | 1 | Registered carry / inverted borrow flag |
| upd_z_q | output | 1 | Z may be written by this operation |
| upd_dc_q | output | 1 | DC may be written by this operation |
| upd_c_q | output | 1 | C may be written by this operation |

## Verification
The bench builds the block with DATA_W = 8, the default. At that width every one of the 65,536 operand pairs for add and subtract fits within the run. This covers every nibble-carry and borrow boundary and the wrap to zero. The unary, logic and rotate operation codes, including the unused ones, are swept over all 256 values of opd_a with both carry-in values. This exposes every shifted-out bit and every zero result. A reset applied in the middle of traffic checks that the registers clear.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_RLC  = 4'd5,
        OP_RRC  = 4'd6,
        OP_SWAP = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_PASS = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flag_t;

    localparam flag_t MASK_NONE = 3'b000;
    localparam flag_t MASK_Z    = 3'b100;
    localparam flag_t MASK_C    = 3'b001;
    localparam flag_t MASK_ALL  = 3'b111;

    // Which flags an operation is permitted to change.
    function automatic flag_t mask_for(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB:                 return MASK_ALL;
            OP_AND, OP_OR, OP_XOR:          return MASK_Z;
            OP_INC, OP_DEC:                 return MASK_Z;
            OP_RLC, OP_RRC:                 return MASK_C;
            default:                        return MASK_NONE;
        endcase
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              nib_c,
    output logic              top_c
);
    localparam int LO_W = DATA_W / 2;
    localparam int HI_W = DATA_W - LO_W;

    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    // Split at the nibble boundary so the half carry is a real adder output.
    always_comb begin
        lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
        hi_sum = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b[DATA_W-1:LO_W]}
               + {{HI_W{1'b0}}, lo_sum[LO_W]};
        sum    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        nib_c  = lo_sum[LO_W];
        top_c  = hi_sum[HI_W];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              shout
);
    localparam int LO_W = DATA_W / 2;

    always_comb begin
        res   = '0;
        shout = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_RLC: begin
                res   = {a[DATA_W-2:0], cin};
                shout = a[DATA_W-1];
            end
            OP_RRC: begin
                res   = {cin, a[DATA_W-1:1]};
                shout = a[0];
            end
            OP_SWAP: res = {a[LO_W-1:0], a[DATA_W-1:LO_W]};
            OP_PASS: res = a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output flag_t             flg,
    output flag_t             msk
);
    alu_op_e           op;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_nib_c;
    logic              add_top_c;
    logic [DATA_W-1:0] bit_res;
    logic              bit_shout;
    logic              arith;
    flag_t             raw;

    assign op    = alu_op_e'(op_code);
    assign arith = is_arith(op);

    // Operand conditioning: subtraction and decrement go through the same adder.
    always_comb begin
        add_b   = b;
        add_cin = 1'b0;
        case (op)
            OP_SUB: begin add_b = ~b;  add_cin = 1'b1; end
            OP_INC: begin add_b = '0;  add_cin = 1'b1; end
            OP_DEC: begin add_b = '1;  add_cin = 1'b0; end
            default: ;
        endcase
    end

    alu_adder #(.DATA_W(DATA_W)) u_add (
        .a     (a),
        .b     (add_b),
        .cin   (add_cin),
        .sum   (add_sum),
        .nib_c (add_nib_c),
        .top_c (add_top_c)
    );

    alu_bitops #(.DATA_W(DATA_W)) u_bit (
        .op    (op),
        .a     (a),
        .b     (b),
        .cin   (cin),
        .res   (bit_res),
        .shout (bit_shout)
    );

    always_comb begin
        res    = arith ? add_sum : bit_res;
        msk    = mask_for(op);
        raw.z  = (res == '0);
        raw.dc = add_nib_c;
        raw.c  = arith ? add_top_c : bit_shout;
        flg    = raw & msk;
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic              c_in,
    output logic [DATA_W-1:0] res_q,
    output logic              z_q,
    output logic              dc_q,
    output logic              c_q,
    output logic              upd_z_q,
    output logic              upd_dc_q,
    output logic              upd_c_q
);
    logic [DATA_W-1:0] res_d;
    flag_t             flg_d;
    flag_t             msk_d;
    flag_t             flg_q;
    flag_t             msk_q;

    alu_core #(.DATA_W(DATA_W)) u_core (
        .op_code (op_code),
        .a       (opd_a),
        .b       (opd_b),
        .cin     (c_in),
        .res     (res_d),
        .flg     (flg_d),
        .msk     (msk_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            flg_q <= MASK_NONE;
            msk_q <= MASK_NONE;
        end else begin
            res_q <= res_d;
            flg_q <= flg_d;
            msk_q <= msk_d;
        end
    end

    assign z_q      = flg_q.z;
    assign dc_q     = flg_q.dc;
    assign c_q      = flg_q.c;
    assign upd_z_q  = msk_q.z;
    assign upd_dc_q = msk_q.dc;
    assign upd_c_q  = msk_q.c;

    // R2: carry after subtraction is the inverted borrow
    a_r2_sub_borrow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_SUB)
        |-> (c_q == ($past(opd_a) >= $past(opd_b))));

    // R3: zero flag agrees with the registered result whenever Z is enabled
    a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
        upd_z_q |-> (z_q == (res_q == '0)));

    // R4: logic operations touch only Z
    a_r4_logic_mask: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(op_code) == OP_AND || $past(op_code) == OP_OR
                         || $past(op_code) == OP_XOR))
        |-> (upd_z_q && !upd_dc_q && !upd_c_q));

    // R5: rotate left takes the old carry in and the top bit out
    a_r5_rlc_carry: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_code) == OP_RLC)
        |-> (c_q == $past(opd_a[DATA_W-1]) && res_q[0] == $past(c_in)));

    // R8: a flag outside the mask is never asserted
    a_r8_masked_zero: assert property (@(posedge clk) disable iff (rst)
        ((z_q && !upd_z_q) || (dc_q && !upd_dc_q) || (c_q && !upd_c_q)) == 1'b0);

    // R9: reset clears every output register on the next edge
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !upd_z_q && !upd_dc_q && !upd_c_q && !z_q && !dc_q && !c_q));
endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_code = '0;
    logic [W-1:0] opd_a = '0;
    logic [W-1:0] opd_b = '0;
    logic         c_in = 1'b0;
    logic [W-1:0] res_q;
    logic         z_q, dc_q, c_q, upd_z_q, upd_dc_q, upd_c_q;

    int n_chk  = 0;
    int n_fail = 0;
    logic      pend = 1'b0;
    logic [13:0] exp_v;
    string     exp_tag;

    always #2 clk = ~clk;

    alu_flag_unit #(.DATA_W(W)) u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .opd_a(opd_a), .opd_b(opd_b),
        .c_in(c_in), .res_q(res_q), .z_q(z_q), .dc_q(dc_q), .c_q(c_q),
        .upd_z_q(upd_z_q), .upd_dc_q(upd_dc_q), .upd_c_q(upd_c_q)
    );

    function automatic string tag_of(int op);
        case (op)
            0: return "R1/R3";
            1: return "R2/R3";
            2, 3, 4: return "R4/R3";
            5, 6: return "R5";
            7, 10: return "R6";
            8, 9: return "R7/R3";
            default: return "R8";
        endcase
    endfunction

    // Packed as {result, z, dc, c, upd_z, upd_dc, upd_c}
    function automatic logic [13:0] model(int op, int a, int b, int ci);
        int r, z, dc, c, m;
        r = 0; dc = 0; c = 0; m = 0;
        case (op)
            0: begin r = (a + b) & 255; c = (a + b > 255); dc = ((a & 15) + (b & 15) > 15); m = 7; end
            1: begin r = (a - b) & 255; c = (a >= b); dc = ((a & 15) >= (b & 15)); m = 7; end
            2: begin r = a & b; m = 4; end
            3: begin r = a | b; m = 4; end
            4: begin r = a ^ b; m = 4; end
            5: begin r = ((a << 1) | ci) & 255; c = (a >> 7) & 1; m = 1; end
            6: begin r = (ci << 7) | (a >> 1); c = a & 1; m = 1; end
            7: begin r = ((a & 15) << 4) | (a >> 4); m = 0; end
            8: begin r = (a + 1) & 255; m = 4; end
            9: begin r = (a + 255) & 255; m = 4; end
            10: begin r = a; m = 0; end
            default: begin r = 0; m = 0; end
        endcase
        z = ((m & 4) != 0) && (r == 0);
        if ((m & 2) == 0) dc = 0;
        if ((m & 1) == 0) c = 0;
        return {r[7:0], z[0], dc[0], c[0], m[2:0]};
    endfunction

    task automatic check_pending();
        logic [13:0] act;
        act = {res_q, z_q, dc_q, c_q, upd_z_q, upd_dc_q, upd_c_q};
        if (pend) begin
            n_chk++;
            if (act !== exp_v) begin
                n_fail++;
                $display("FAIL %s: actual=%h expected=%h", exp_tag, act, exp_v);
            end
        end
        pend = 1'b0;
    endtask

    task automatic step(input int op, input int a, input int b, input int ci);
        @(negedge clk);
        check_pending();
        op_code = op[3:0];
        opd_a   = a[7:0];
        opd_b   = b[7:0];
        c_in    = ci[0];
        exp_v   = model(op, a, b, ci);
        exp_tag = tag_of(op);
        pend    = 1'b1;
    endtask

    task automatic check_zero(input string what);
        logic [13:0] act;
        act = {res_q, z_q, dc_q, c_q, upd_z_q, upd_dc_q, upd_c_q};
        n_chk++;
        if (act !== 14'd0) begin
            n_fail++;
            $display("FAIL R9 %s: actual=%h expected=0000", what, act);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("reset state");
        @(negedge clk);
        rst = 1'b0;

        // Unary, logic, rotate and unused codes: every opd_a, both carry-in values
        for (int op = 2; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++)
                    step(op, a, a ^ 8'h5a ^ (ci * 8'h81), ci);

        // Mid-traffic reset: load non-zero outputs, then reset
        step(0, 200, 100, 0);
        @(negedge clk);
        check_pending();
        rst = 1'b1;
        op_code = 4'd0; opd_a = 8'hff; opd_b = 8'h01;
        @(negedge clk);
        check_zero("mid-run reset");
        rst = 1'b0;

        // Add and subtract: every operand pair
        for (int op = 0; op < 2; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    step(op, a, b, (a + b) & 1);

        @(negedge clk);
        check_pending();
        finish_run();
    end
endmodule